// File: doc/BRIEF.md
# Serial Audio Input Port (Slave Receiver)

This block receives two-channel PCM audio from an external source that owns the clocks. A bit clock, a word clock and a serial data line are sampled by the system clock. At each active bit-clock edge the block records the data bit and the word-clock level. A change of word-clock level marks the start of a new half-frame. At that point the half-frame that just ended is converted into a sample.

Static control inputs select several settings. They select the sample resolution, and whether the sample is taken from the start of the half-frame or from its end. They select an optional one-bit offset of the first data bit, which bit-clock edge samples the data, and which word-clock level stands for channel A. With these settings one datapath covers left-justified, I2S-style and right-justified streams.

Both samples of a frame are presented together, MSB-aligned in a fixed-width word. A single-cycle strobe marks each new pair. The control inputs are expected to change only while reset is asserted.

Top module: `sai_rx_port`

## Requirements
- R1: While reset is asserted and after it is released, `smp_valid_o` is low and both sample outputs are zero until the first complete frame has been received.
- R2: `res_sel_i` selects the resolution N: 00 gives 24 bits, 01 gives 20 bits, 10 gives 16 bits, and 11 is treated as 24 bits. Each sample appears left-aligned in the 24-bit output, and the 24-N low bits are zero.
- R3: With `rjust_i`=0 and `msb_dly_i`=0, the MSB of a sample is the bit captured at the first active bit-clock edge that sees the new word-clock level. The following N-1 edges supply the remaining bits, MSB first.
- R4: With `rjust_i`=0 and `msb_dly_i`=1, the bit at the first edge of a half-frame is discarded, and the MSB is the bit at the second edge.
- R5: With `rjust_i`=0, a half-frame may hold any number of bit clocks. Bits after the N-th data bit are ignored. If the half-frame ends before N data bits arrive, the missing positions read as zero.
- R6: With `rjust_i`=1, the sample is formed from the last N bits received before the word-clock change, and `msb_dly_i` has no effect. If fewer than N bits arrive, the missing upper positions read as zero.
- R7: `bclk_fall_i`=0 samples data and word clock on bit-clock rising edges. `bclk_fall_i`=1 samples them on falling edges.
- R8: `wclk_pol_i`=0 treats a high word clock as channel A. `wclk_pol_i`=1 treats a low word clock as channel A.
- R9: The half-frame that is in progress when the first word-clock change is seen after reset is discarded. `smp_valid_o` pulses for exactly one cycle each time a channel B half-frame ends after a channel A half-frame. The A and B samples are presented together. The sample outputs change only in a cycle where `smp_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (sampled) |
| wclk_i | input | 1 | Word clock, channel select (sampled) |
| sd_i | input | 1 | Serial data, MSB first |
| res_sel_i | input | 2 | Resolution select (R2) |
| rjust_i | input | 1 | 0 start-aligned, 1 end-aligned (R3, R6) |
| msb_dly_i | input | 1 | One bit-clock offset of the MSB (R4) |
| bclk_fall_i | input | 1 | Sampling edge select (R7) |
| wclk_pol_i | input | 1 | Word-clock level for channel A (R8) |
| smp_a_o | output | SMP_W | Channel A sample, left-aligned |
| smp_b_o | output | SMP_W | Channel B sample, left-aligned |
| smp_valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
Each input change reaches the decision logic after two synchronizer flops. A pair is therefore registered on the third clock edge after the active bit-clock edge that opens the next channel A half-frame. The bench drives every bit-clock phase for at least two system-clock cycles, so each pair lands well before the next active edge. It queues the expected pair before sending the frame, and a monitor samples on falling system-clock edges. The monitor compares the pair as soon as the strobe appears, flags any strobe longer than one cycle or with no pending expectation, and checks at the end of each stream that every queued pair has been delivered.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

    typedef enum logic [1:0] {
        RES_24  = 2'b00,
        RES_20  = 2'b01,
        RES_16  = 2'b10,
        RES_ALT = 2'b11
    } res_e;

    typedef struct packed {
        logic bclk;
        logic wclk;
        logic sd;
    } pins_t;

    // Number of sample bits kept for a given resolution code.
    function automatic int unsigned res_bits(res_e sel, int unsigned full_w);
        case (sel)
            RES_20:  return full_w - 4;
            RES_16:  return full_w - 8;
            default: return full_w;
        endcase
    endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync
    import sai_rx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic wclk_i,
    input  logic sd_i,
    input  logic fall_sel_i,
    output logic act_o,
    output logic wclk_o,
    output logic sd_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    pins_t [DEPTH-1:0] pipe_q, pipe_d;
    pins_t             cur, old;

    always_comb begin
        pipe_d[0] = '{bclk: bclk_i, wclk: wclk_i, sd: sd_i};
        for (int k = 1; k < DEPTH; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign cur    = pipe_q[STAGES-1];
    assign old    = pipe_q[STAGES];
    assign act_o  = fall_sel_i ? (old.bclk & ~cur.bclk) : (~old.bclk & cur.bclk);
    assign wclk_o = cur.wclk;
    assign sd_o   = cur.sd;

    // Two active edges of one direction are always at least two cycles apart.
    p_act_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |=> !act_o);

endmodule

// File: rtl/sai_rx_slot.sv
module sai_rx_slot
    import sai_rx_pkg::*;
#(
    parameter int unsigned SMP_W = 24,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             bound_i,
    input  logic             bit_i,
    input  logic             rjust_i,
    input  logic             dly_i,
    input  res_e             res_i,
    output logic [SMP_W-1:0] word_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [SMP_W-1:0] lj;
        logic [SMP_W-1:0] rj;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t            cr_q, cr_d;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] eff_dly;
    logic [SMP_W-1:0] lj_base, rj_base, rj_w;
    int unsigned      res_n;

    assign res_n   = res_bits(res_i, SMP_W);
    assign eff_dly = (dly_i && !rjust_i) ? CNT_W'(1) : '0;

    always_comb begin
        cr_d    = cr_q;
        pos     = bound_i ? '0 : cr_q.cnt;
        lj_base = bound_i ? '0 : cr_q.lj;
        rj_base = bound_i ? '0 : cr_q.rj;
        if (act_i) begin
            cr_d.rj = {rj_base[SMP_W-2:0], bit_i};
            cr_d.lj = lj_base;
            for (int i = 0; i < SMP_W; i++) begin
                if (i < res_n && pos == CNT_W'(i) + eff_dly) begin
                    cr_d.lj[SMP_W-1-i] = bit_i;
                end
            end
            cr_d.cnt = (pos == CNT_MAX) ? pos : pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign rj_w   = cr_q.rj << (SMP_W - res_n);
    assign word_o = rjust_i ? rj_w : cr_q.lj;

    // A word-clock change restarts the bit position of the half-frame.
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && bound_i) |=> (cr_q.cnt == CNT_W'(1)));

endmodule

// File: rtl/sai_rx_port.sv
module sai_rx_port
    import sai_rx_pkg::*;
#(
    parameter int unsigned SMP_W       = 24,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             wclk_i,
    input  logic             sd_i,
    input  logic [1:0]       res_sel_i,
    input  logic             rjust_i,
    input  logic             msb_dly_i,
    input  logic             bclk_fall_i,
    input  logic             wclk_pol_i,
    output logic [SMP_W-1:0] smp_a_o,
    output logic [SMP_W-1:0] smp_b_o,
    output logic             smp_valid_o
);
    localparam int unsigned LSB16 = SMP_W - 16;
    localparam int unsigned LSB20 = SMP_W - 20;

    typedef struct packed {
        logic             started;
        logic             wclk_prev;
        logic             aligned;
        logic             have_a;
        logic [SMP_W-1:0] a_hold;
        logic [SMP_W-1:0] out_a;
        logic [SMP_W-1:0] out_b;
        logic             valid;
    } port_t;

    port_t            st_q, st_d;
    logic             act, wclk_s, sd_s, bound, prev_is_a;
    logic [SMP_W-1:0] half_word;
    res_e             res;

    assign res = res_e'(res_sel_i);

    sai_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .wclk_i    (wclk_i),
        .sd_i      (sd_i),
        .fall_sel_i(bclk_fall_i),
        .act_o     (act),
        .wclk_o    (wclk_s),
        .sd_o      (sd_s)
    );

    assign bound     = act && st_q.started && (wclk_s != st_q.wclk_prev);
    assign prev_is_a = st_q.wclk_prev ^ wclk_pol_i;

    sai_rx_slot #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .bound_i(bound),
        .bit_i  (sd_s),
        .rjust_i(rjust_i),
        .dly_i  (msb_dly_i),
        .res_i  (res),
        .word_o (half_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (act) begin
            st_d.started   = 1'b1;
            st_d.wclk_prev = wclk_s;
        end
        if (bound) begin
            st_d.aligned = 1'b1;
            if (st_q.aligned) begin
                if (prev_is_a) begin
                    st_d.a_hold = half_word;
                    st_d.have_a = 1'b1;
                end else if (st_q.have_a) begin
                    st_d.out_a  = st_q.a_hold;
                    st_d.out_b  = half_word;
                    st_d.valid  = 1'b1;
                    st_d.have_a = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_a_o     = st_q.out_a;
    assign smp_b_o     = st_q.out_b;
    assign smp_valid_o = st_q.valid;

    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o);

    p_valid_from_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> $past(act));

    p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |-> ($stable(smp_a_o) && $stable(smp_b_o)));

    p_lsb16_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && res == RES_16) |->
            (smp_a_o[LSB16-1:0] == '0 && smp_b_o[LSB16-1:0] == '0));

    p_lsb20_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && res == RES_20) |->
            (smp_a_o[LSB20-1:0] == '0 && smp_b_o[LSB20-1:0] == '0));

endmodule

// File: tb/sai_rx_port_bench.sv
`timescale 1ns/1ps
module sai_rx_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, wclk = 1'b0, sd = 1'b0;
    logic [1:0]  res_sel = 2'b00;
    logic        rjust = 1'b0, dly = 1'b0, fall = 1'b0, pol = 1'b0;
    logic [23:0] smp_a, smp_b;
    logic        smp_valid;

    int          n_chk = 0, n_fail = 0;
    logic [47:0] exp_q[$];
    string       tag_q[$];
    logic        prev_valid = 1'b0;
    logic [0:63] arr_a, arr_b;
    int          cyc = 0;

    always #4 clk = ~clk;

    sai_rx_port u_sai_rx_port (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sd_i(sd),
        .res_sel_i(res_sel), .rjust_i(rjust), .msb_dly_i(dly),
        .bclk_fall_i(fall), .wclk_pol_i(pol),
        .smp_a_o(smp_a), .smp_b_o(smp_b), .smp_valid_o(smp_valid)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            finish_run();
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (prev_valid) begin
                n_chk++; n_fail++;
                $display("FAIL R9 strobe width actual=2+ expected=1");
            end else if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected pair actual=%h/%h expected=none", smp_a, smp_b);
            end else begin
                logic [47:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " chA"}, smp_a, e[47:24]);
                check({t, " chB"}, smp_b, e[23:0]);
            end
        end
        prev_valid = rst_n && smp_valid;
    end

    function automatic logic [23:0] exp_word(logic [0:63] v, int len);
        logic [23:0] r = '0;
        int n = (res_sel == 2'b01) ? 20 : (res_sel == 2'b10) ? 16 : 24;
        for (int i = 0; i < n; i++) begin
            if (!rjust) begin
                int p = i + (dly ? 1 : 0);
                if (p < len) r[23-i] = v[p];
            end else begin
                int p = len - 1 - i;
                if (p >= 0) r[i+24-n] = v[p];
            end
        end
        return r;
    endfunction

    task automatic send_bit(input logic b, input logic w);
        bclk = fall;
        repeat (2) @(negedge clk);
        sd = b; wclk = w;
        repeat (2) @(negedge clk);
        bclk = ~fall;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_half(input logic [0:63] v, input int len, input logic is_a);
        logic w = is_a ? ~pol : pol;
        for (int i = 0; i < len; i++) send_bit(v[i], w);
    endtask

    task automatic configure(input logic [1:0] r, input logic rj, input logic d,
                             input logic f, input logic p);
        rst_n = 1'b0;
        res_sel = r; rjust = rj; dly = d; fall = f; pol = p;
        bclk = f; wclk = p; sd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic gen(output logic [0:63] v);
        for (int i = 0; i < 64; i++) v[i] = 1'($urandom);
    endtask

    task automatic run_stream(input string tag, input int nfr, input int la, input int lb);
        logic [0:63] junk;
        gen(junk);
        send_half(junk, 7, 1'b0);          // partial half-frame, discarded
        for (int f = 0; f < nfr; f++) begin
            gen(arr_a); gen(arr_b);
            exp_q.push_back({exp_word(arr_a, la), exp_word(arr_b, lb)});
            tag_q.push_back(tag);
            send_half(arr_a, la, 1'b1);
            send_half(arr_b, lb, 1'b0);
        end
        gen(junk);
        send_half(junk, 3, 1'b1);          // closes the last channel B half
        repeat (16) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 %s pending pairs actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset chA", smp_a, 24'h0);
        check("R1 reset chB", smp_b, 24'h0);
        check("R1 reset valid", {23'h0, smp_valid}, 24'h0);

        configure(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 idle valid", {23'h0, smp_valid}, 24'h0);
        run_stream("R3 left-justified 24b", 3, 24, 24);

        configure(2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
        run_stream("R4 R8 delayed MSB, low=A", 3, 32, 32);

        configure(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        run_stream("R2 R5 16b extra bits ignored", 2, 32, 24);

        configure(2'b01, 1'b0, 1'b1, 1'b0, 1'b1);
        run_stream("R5 R2 20b short half zero fill", 2, 12, 16);

        configure(2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        run_stream("R6 right-justified delay ignored", 3, 32, 28);

        configure(2'b10, 1'b1, 1'b0, 1'b0, 1'b1);
        run_stream("R6 R2 right-justified 16b short", 2, 20, 10);

        configure(2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        run_stream("R7 falling-edge sampling", 3, 24, 24);

        configure(2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
        run_stream("R2 R8 code 11 as 24b", 2, 24, 30);

        finish_run();
    end
endmodule